// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a virtual page number into a physical page number. It reads a forward-mapped page table with three levels through a single memory port. A small root table holds entries that point to middle tables. Middle-table entries point to leaf tables, and a leaf entry holds the translation and the status bits of the page. The byte offset inside a 4 KB page is not translated. It is appended to the physical page number unchanged.

The walker has two search strategies. In top-down mode it starts at the root and reads one entry per level. In bottom-up mode it first reads the leaf entry directly from a linearly laid-out leaf region. If that entry is valid, the walker uses it at once. If it is not valid, the walker falls back to a full top-down walk from the root.

On the final entry the walker checks the valid bit and the protection field against the access type. If the access is allowed, it sets the reference bit, and it sets the dirty bit on a write. The updated entry is written back in one write, and only when one of those bits changes. Each accepted request ends with exactly one one-cycle response: success with the translation, page fault, or protection fault.

Top module: `page_walker`

## Requirements
- R1: In top-down mode the walker reads three entries in order: root, then middle, then leaf. On success it pulses `done` for one cycle with `res_ppn` equal to bits [31:12] of the leaf entry and `res_pa` equal to {`res_ppn`, `req_off`}.
- R2: A walk entry's address is (base page number << 12) + index * 4. The root base is `root_ppn`, and each lower base comes from bits [31:12] of the entry above. The indices are `req_vpn` [17:12], [11:6] and [5:0] for the root, middle and leaf levels.
- R3: In bottom-up mode the first read is at `flat_base` + `req_vpn` * 4. If bit 0 of that entry is set, the walker checks that entry as the final entry and makes no other table read.
- R4: In bottom-up mode, if the probed entry has bit 0 clear, the walker then does a full top-down walk from the root. That makes four reads when the tree is valid.
- R5: If a root or middle entry has its valid bit (bit 0) clear, the walk ends with a `page_fault` pulse. No further read and no write follows.
- R6: If the final entry has its valid bit clear, the walker pulses `page_fault` and makes no write.
- R7: The protection field is bits [2:1] of the final entry: 0 = no access, 1 = read-only, 2 = execute, 3 = read/write. Access type 0 = read is allowed for 1 or 3, 1 = write is allowed for 3 only, 2 = execute is allowed for 2 only, and 3 is never allowed. A refused access pulses `prot_fault` and makes no write.
- R8: On an allowed access the walker sets bit 3 (reference) of the final entry, and on a write it also sets bit 4 (dirty). It writes the whole entry back to the address it was read from in one write, and only if the value changed.
- R9: `req_ready` is high only when the walker is idle. A `req_valid` seen while busy is ignored. Each accepted request gives exactly one one-cycle pulse on one of `done`, `page_fault` or `prot_fault`.
- R10: Counted from the clock edge that accepts the request, the response pulse begins 2 cycles per read plus 1 cycle when a write is made. Each read is followed by a cycle with no memory access.
- R11: After reset `req_ready` is high, and no memory enable and no response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vpn | input | 18 | Virtual page number |
| req_off | input | 12 | Byte offset within the page |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_bottom_up | input | 1 | 1 selects the leaf probe first |
| root_ppn | input | 20 | Page number of the root table |
| flat_base | input | 32 | Byte address of the linear leaf region |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value, valid the cycle after the read strobe |
| done | output | 1 | Successful translation pulse |
| page_fault | output | 1 | Non-resident entry pulse |
| prot_fault | output | 1 | Access refused pulse |
| res_ppn | output | 20 | Physical page number |
| res_pa | output | 32 | Physical byte address |

## Verification
The hardest case to reach from the ports is the bottom-up fallback. The probe must miss while the tree behind it is valid, so the walk finishes as a full descent and not as a fault. The bench sets this up by loading the linear leaf region and the tree with different contents for the same page number. It then checks that the probe address comes first, followed by the three tree addresses in order. A request pulsed while a walk is in flight is also driven mid-walk, and the bench confirms that it gives no read and no response.

// File: rtl/page_walker.sv
module page_walker #(
  parameter int LVL_W = 6,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32,
  localparam int VPN_W = 3 * LVL_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  input  logic             req_bottom_up,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic [PA_W-1:0]  flat_base,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             done,
  output logic             page_fault,
  output logic             prot_fault,
  output logic [PPN_W-1:0] res_ppn,
  output logic [PA_W-1:0]  res_pa
);
  localparam int ENT_SH = $clog2(PTE_W / 8);
  localparam int B_REF  = 3;
  localparam int B_DRT  = 4;
  localparam logic [1:0] LEAF = 2'd2;
  localparam logic [1:0] RS_OK = 2'd0, RS_PF = 2'd1, RS_PROT = 2'd2;

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_EVAL, ST_WRITE, ST_RESP} state_t;

  state_t           state;
  logic [1:0]       lvl;
  logic             probe;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       acc_q;
  logic [PPN_W-1:0] root_q;
  logic [PA_W-1:0]  addr_q;
  logic [PTE_W-1:0] pte_q;
  logic [PPN_W-1:0] ppn_q;
  logic [1:0]       stat_q;

  function automatic logic [PA_W-1:0] ent_addr(input logic [PPN_W-1:0] base,
                                               input logic [LVL_W-1:0] idx);
    return {base, {OFF_W{1'b0}}} + (PA_W'(idx) << ENT_SH);
  endfunction

  function automatic logic [LVL_W-1:0] idx_of(input logic [VPN_W-1:0] v,
                                              input logic [1:0] l);
    return v[(2 - int'(l)) * LVL_W +: LVL_W];
  endfunction

  wire             rd_valid = mem_rdata[0];
  wire [1:0]       rd_perm  = mem_rdata[2:1];
  wire [PPN_W-1:0] rd_ppn   = mem_rdata[PTE_W-1 -: PPN_W];

  logic             perm_ok;
  logic [PTE_W-1:0] upd;

  always_comb begin
    case (acc_q)
      2'd0:    perm_ok = rd_perm[0];
      2'd1:    perm_ok = (rd_perm == 2'd3);
      2'd2:    perm_ok = (rd_perm == 2'd2);
      default: perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    upd = mem_rdata;
    upd[B_REF] = 1'b1;
    if (acc_q == 2'd1) upd[B_DRT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lvl    <= '0;
      probe  <= 1'b0;
      vpn_q  <= '0;
      off_q  <= '0;
      acc_q  <= '0;
      root_q <= '0;
      addr_q <= '0;
      pte_q  <= '0;
      ppn_q  <= '0;
      stat_q <= RS_OK;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          vpn_q  <= req_vpn;
          off_q  <= req_off;
          acc_q  <= req_acc;
          root_q <= root_ppn;
          probe  <= req_bottom_up;
          lvl    <= req_bottom_up ? LEAF : 2'd0;
          addr_q <= req_bottom_up ? flat_base + (PA_W'(req_vpn) << ENT_SH)
                                  : ent_addr(root_ppn, idx_of(req_vpn, 2'd0));
          state  <= ST_READ;
        end
        ST_READ: state <= ST_EVAL;
        ST_EVAL: begin
          if (!rd_valid) begin
            if (probe) begin
              probe  <= 1'b0;
              lvl    <= 2'd0;
              addr_q <= ent_addr(root_q, idx_of(vpn_q, 2'd0));
              state  <= ST_READ;
            end else begin
              stat_q <= RS_PF;
              state  <= ST_RESP;
            end
          end else if (lvl != LEAF) begin
            lvl    <= lvl + 2'd1;
            addr_q <= ent_addr(rd_ppn, idx_of(vpn_q, lvl + 2'd1));
            state  <= ST_READ;
          end else if (!perm_ok) begin
            stat_q <= RS_PROT;
            state  <= ST_RESP;
          end else begin
            stat_q <= RS_OK;
            ppn_q  <= rd_ppn;
            pte_q  <= upd;
            state  <= (upd != mem_rdata) ? ST_WRITE : ST_RESP;
          end
        end
        ST_WRITE: state <= ST_RESP;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign mem_rd_en  = (state == ST_READ);
  assign mem_wr_en  = (state == ST_WRITE);
  assign mem_addr   = addr_q;
  assign mem_wdata  = pte_q;
  assign done       = (state == ST_RESP) && (stat_q == RS_OK);
  assign page_fault = (state == ST_RESP) && (stat_q == RS_PF);
  assign prot_fault = (state == ST_RESP) && (stat_q == RS_PROT);
  assign res_ppn    = ppn_q;
  assign res_pa     = {ppn_q, off_q};
endmodule

// File: rtl/page_walker_sva.sv
module page_walker_sva #(
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [PTE_W-1:0] mem_wdata,
  input logic             done,
  input logic             page_fault,
  input logic             prot_fault
);
  wire any_resp = done | page_fault | prot_fault;

  p_single_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, page_fault, prot_fault}) <= 1);

  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_resp |=> !any_resp && req_ready);

  p_accept_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

  p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> !req_ready);

  p_read_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en && !mem_wr_en);

  p_wr_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> done);

  p_wr_sets_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_wdata[3]);

  p_fault_no_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (page_fault || prot_fault) |-> !$past(mem_wr_en));
endmodule

bind page_walker page_walker_sva #(.PTE_W(PTE_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
  .done(done), .page_fault(page_fault), .prot_fault(prot_fault)
);

// File: tb/test_page_walker.sv
`timescale 1ns/1ps
module test_page_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_vpn = '0;
  logic [11:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        req_bottom_up = 1'b0;
  logic [19:0] root_ppn = 20'h00010;
  logic [31:0] flat_base = 32'h0080_0000;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        done, page_fault, prot_fault;
  logic [19:0] res_ppn;
  logic [31:0] res_pa;

  always #2.5 clk = ~clk;

  page_walker i_page_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_off(req_off), .req_acc(req_acc),
    .req_bottom_up(req_bottom_up), .root_ppn(root_ppn), .flat_base(flat_base),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .page_fault(page_fault), .prot_fault(prot_fault), .res_ppn(res_ppn),
    .res_pa(res_pa)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] exp_rd [$];
  bit          wr_pend = 0;
  logic [31:0] wr_addr_e, wr_data_e;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= rdm(mem_addr);
    if (mem_wr_en) mem[mem_addr] = mem_wdata;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_rd_en) begin
      if (exp_rd.size() == 0) chk(0, "R9", "unexpected read", mem_addr, 0);
      else begin
        logic [31:0] e;
        e = exp_rd.pop_front();
        chk(mem_addr == e, "R2", "read address", mem_addr, e);
      end
    end
    if (mem_wr_en) begin
      chk(wr_pend, "R8", "unexpected write", mem_addr, 0);
      if (wr_pend) begin
        chk(mem_addr == wr_addr_e, "R8", "write address", mem_addr, wr_addr_e);
        chk(mem_wdata == wr_data_e, "R8", "write data", mem_wdata, wr_data_e);
      end
      wr_pend = 0;
    end
  end

  function automatic logic [31:0] mk(input logic [19:0] ppn, input logic [1:0] perm,
                                     input bit r, input bit d, input bit v);
    return {ppn, 7'b0, d, r, perm, v};
  endfunction

  function automatic logic [31:0] ea(input logic [19:0] base, input logic [5:0] idx);
    return {base, 12'h0} + {24'h0, idx, 2'b00};
  endfunction

  task automatic map_page(input logic [17:0] vpn, input logic [19:0] mid,
                          input logic [19:0] leaf, input logic [31:0] pte);
    mem[ea(root_ppn, vpn[17:12])] = mk(mid, 2'd0, 0, 0, 1);
    mem[ea(mid, vpn[11:6])]       = mk(leaf, 2'd0, 0, 0, 1);
    mem[ea(leaf, vpn[5:0])]       = pte;
  endtask

  task automatic run(input logic [17:0] vpn, input logic [11:0] off, input logic [1:0] acc,
                     input bit bu, input bit poke, input string rq);
    int nrd = 0;
    int wr = 0;
    int st = 0;
    int k = 0;
    bit fin = 0;
    bit leaf_ok = 0;
    logic [31:0] a, pte, nw;
    logic [19:0] base;
    logic [19:0] eppn = '0;
    bit allow;
    exp_rd.delete();
    if (bu) begin
      a = flat_base + {12'h0, vpn, 2'b00};
      exp_rd.push_back(a); nrd++;
      pte = rdm(a);
      if (pte[0]) leaf_ok = 1;
    end
    if (!leaf_ok) begin
      base = root_ppn;
      for (int l = 0; l < 3 && !fin; l++) begin
        a = ea(base, vpn[17 - 6*l -: 6]);
        exp_rd.push_back(a); nrd++;
        pte = rdm(a);
        if (!pte[0]) begin st = 1; fin = 1; end
        else if (l < 2) base = pte[31:12];
        else leaf_ok = 1;
      end
    end
    if (leaf_ok) begin
      case (acc)
        2'd0: allow = (pte[2:1] == 2'd1) || (pte[2:1] == 2'd3);
        2'd1: allow = (pte[2:1] == 2'd3);
        2'd2: allow = (pte[2:1] == 2'd2);
        default: allow = 0;
      endcase
      if (!allow) st = 2;
      else begin
        eppn = pte[31:12];
        nw = pte | 32'h8 | ((acc == 2'd1) ? 32'h10 : 32'h0);
        if (nw != pte) begin wr = 1; wr_pend = 1; wr_addr_e = a; wr_data_e = nw; end
      end
    end
    req_vpn = vpn; req_off = off; req_acc = acc; req_bottom_up = bu; req_valid = 1;
    while (1) begin
      @(negedge clk);
      k++;
      req_valid = 0;
      if (poke && k == 2) begin req_vpn = 18'h3ffff; req_bottom_up = 0; req_valid = 1; end
      if (done || page_fault || prot_fault) break;
      if (k > 200) begin chk(0, rq, "watchdog", k, 0); break; end
    end
    req_valid = 0;
    chk(done == (st == 0) && page_fault == (st == 1) && prot_fault == (st == 2), rq,
        "response kind", {done, page_fault, prot_fault}, st);
    if (st == 0) begin
      chk(res_ppn == eppn, rq, "ppn", res_ppn, eppn);
      chk(res_pa == {eppn, off}, rq, "pa", res_pa, {eppn, off});
    end
    chk(k == 1 + 2*nrd + wr, "R10", "latency", k, 1 + 2*nrd + wr);
    chk(exp_rd.size() == 0, rq, "reads left", exp_rd.size(), 0);
    chk(!wr_pend, "R8", "write missing", wr_pend, 0);
    wr_pend = 0;
    @(negedge clk);
  endtask

  localparam logic [17:0] V1 = {6'd3, 6'd5, 6'd7};
  localparam logic [17:0] V2 = {6'd3, 6'd5, 6'd8};
  localparam logic [17:0] V3 = {6'd3, 6'd6, 6'd1};
  localparam logic [17:0] V4 = {6'd9, 6'd0, 6'd0};
  localparam logic [17:0] V5 = {6'd3, 6'd5, 6'd9};
  localparam logic [17:0] V6 = {6'd3, 6'd5, 6'd10};
  localparam logic [17:0] V7 = {6'd3, 6'd5, 6'd11};

  initial begin
    #(200_000 * 5);
    chk(0, "R9", "global watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    map_page(V1, 20'h00100, 20'h00101, mk(20'hABCDE, 2'd3, 0, 0, 1));
    mem[ea(20'h00101, V2[5:0])]  = mk(20'h12345, 2'd2, 1, 0, 1);
    mem[ea(20'h00101, V5[5:0])]  = mk(20'h0BEEF, 2'd3, 0, 0, 0);
    mem[ea(20'h00101, V6[5:0])]  = mk(20'h00777, 2'd1, 0, 0, 1);
    mem[ea(20'h00101, V7[5:0])]  = mk(20'h00888, 2'd0, 0, 0, 1);
    mem[flat_base + {12'h0, V1, 2'b00}] = mk(20'h55555, 2'd3, 1, 0, 1);
    repeat (4) @(negedge clk);
    chk(req_ready && !mem_rd_en && !mem_wr_en && !done && !page_fault && !prot_fault,
        "R11", "state under reset", {req_ready, mem_rd_en, mem_wr_en}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !mem_rd_en && !done, "R11", "idle after reset", req_ready, 1);

    run(V1, 12'h123, 2'd0, 0, 0, "R1");
    run(V1, 12'h456, 2'd0, 0, 0, "R8");
    run(V1, 12'hFFF, 2'd1, 0, 0, "R8");
    run(V1, 12'h000, 2'd1, 0, 0, "R8");
    run(V2, 12'h010, 2'd2, 0, 0, "R7");
    run(V2, 12'h010, 2'd0, 0, 0, "R7");
    run(V6, 12'h020, 2'd1, 0, 0, "R7");
    run(V6, 12'h030, 2'd0, 0, 0, "R7");
    run(V7, 12'h040, 2'd0, 0, 0, "R7");
    run(V1, 12'h050, 2'd3, 0, 0, "R7");
    run(V4, 12'h060, 2'd0, 0, 0, "R5");
    run(V3, 12'h070, 2'd0, 0, 0, "R5");
    run(V5, 12'h080, 2'd0, 0, 0, "R6");
    run(V1, 12'h090, 2'd0, 1, 0, "R3");
    run(V1, 12'h0A0, 2'd1, 1, 0, "R3");
    run(V2, 12'h0B0, 2'd2, 1, 0, "R4");
    run(V5, 12'h0C0, 2'd0, 1, 0, "R4");
    run(V6, 12'h0D0, 2'd0, 0, 1, "R9");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!done && !page_fault && !prot_fault && !mem_rd_en && req_ready, "R9",
          "ignored request leaves walker idle", {done, page_fault, prot_fault, mem_rd_en}, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule